// File: doc/BRIEF.md
# Limit Interval Timer with Free-Run and User Mode

This block is a processor-local interval timer. An up-counter advances on each `tick` pulse. In counter mode it climbs to a programmable limit. When it gets there it raises a sticky reached flag and an interrupt, and on the next tick it starts again from zero. A stored limit of zero turns the counter into a free-running one that wraps only at the all-ones count. The limit can be rewritten in two ways: one restarts the count and one leaves it alone.

A mode register holds one bit per processor, and this instance reacts to bit `PROC_IDX`. When that bit is set, the timer becomes a software-controlled user timer. In that mode it can be stopped, started and preloaded, it counts across the whole word, and it never interrupts. Registers are selected by a 3-bit word address. Write data is taken when `wr_en` is high. Read data is combinational from `addr`. A read strobe on the resetting-limit address acknowledges the interrupt.

Top module: `lim_timer`

## Requirements
- R1: After reset the count is 0, the reached flag is 0, the limit is all-ones, the timer runs in counter mode (mode bit 0, run bit 1) and `irq` is low.
- R2: In counter mode every `tick` adds one to the count. The cycle the count becomes equal to the effective limit, the reached flag and `irq` are set. The next tick after the count equals the effective limit loads zero.
- R3: A stored limit of zero gives an effective limit of all-ones, so the counter runs past any small value without setting reached or `irq`.
- R4: A write to address 0 stores the limit, sets the count to 0, and clears both the reached flag and `irq`.
- R5: A write to address 2 stores the limit and leaves the count untouched.
- R6: Reads of addresses 0 and 2 return the reached flag in bit W-1 and limit bits W-2:0. A `rd_en` at address 0 lowers `irq` and keeps the reached flag. A reach in the same cycle wins.
- R7: A write to address 4 takes bit `PROC_IDX` as the mode (1 = user timer), and a read returns the mode in that bit. A change of mode clears the count, reached and `irq`. Entering user mode stops the timer, and returning to counter mode runs it.
- R8: In user mode, bit 0 of a write to address 3 starts (1) or stops (0) the count. Address 3 reads the run bit in bit 0. In counter mode, writes to address 3 are ignored.
- R9: In user mode a write to address 1 loads the count and clears reached. A running user timer wraps from all-ones to zero and never raises `irq`. Address 1 reads the count, and addresses 5 to 7 read zero.
- R10: In counter mode a write to address 1 is ignored.
- R11: A register write that changes the count takes precedence over a `tick` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect only) |
| addr | input | 3 | Word address of the register |
| wdata | input | W | Write data |
| rdata | output | W | Read data for `addr` |
| irq | output | 1 | Limit-reached interrupt |

## Verification
Every property assumes that `addr` and the strobes are stable and known at each rising edge. The hold checks also assume that no `tick` arrives in the same cycle, which is why they qualify on `!tick`. The random stimulus keeps stored limits below twelve, so counter-mode reaches happen often. It preloads counts either near zero or close to all-ones, which exercises the user-timer wrap within a few ticks. Directed sequences cover the zero limit, the non-resetting limit write and both directions of the mode switch.

// File: rtl/lim_timer_pkg.sv
package lim_timer_pkg;
   localparam int unsigned SEL_W = 3;
   typedef enum logic [SEL_W-1:0] {
      SEL_LIM_RST  = 3'd0,
      SEL_COUNT    = 3'd1,
      SEL_LIM_KEEP = 3'd2,
      SEL_CTRL     = 3'd3,
      SEL_MODE     = 3'd4
   } sel_e;
endpackage

// File: rtl/lim_timer_cfg.sv
module lim_timer_cfg
   import lim_timer_pkg::*;
#(
   parameter int unsigned W        = 32,
   parameter int unsigned NPROC    = 4,
   parameter int unsigned PROC_IDX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] addr,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     limit_q,
   output logic [W-1:0]     eff_lim,
   output logic             user_q,
   output logic             run_q,
   output logic             mode_sw,
   output logic             lim_rst_wr
);
   logic wr_keep, wr_ctrl, wr_mode, new_user;

   assign lim_rst_wr = wr_en && (addr == SEL_LIM_RST);
   assign wr_keep    = wr_en && (addr == SEL_LIM_KEEP);
   assign wr_ctrl    = wr_en && (addr == SEL_CTRL);
   assign wr_mode    = wr_en && (addr == SEL_MODE);
   assign new_user   = wdata[PROC_IDX];
   assign mode_sw    = wr_mode && (new_user != user_q);
   assign eff_lim    = (limit_q == '0) ? '1 : limit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_q <= '1;
         user_q  <= 1'b0;
         run_q   <= 1'b1;
      end else begin
         if (lim_rst_wr || wr_keep) limit_q <= wdata;
         if (mode_sw) begin
            user_q <= new_user;
            run_q  <= !new_user;
         end else if (wr_ctrl && user_q) begin
            run_q <= wdata[0];
         end
      end
   end
endmodule

// File: rtl/lim_timer_cnt.sv
module lim_timer_cnt #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         user,
   input  logic         run,
   input  logic [W-1:0] eff_lim,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] cnt_q,
   output logic         reached_q,
   output logic         hit
);
   logic         go;
   logic [W-1:0] nxt_ctr, nxt_usr;

   assign go      = tick && (run || !user);
   assign nxt_usr = cnt_q + 1'b1;
   assign nxt_ctr = (cnt_q == eff_lim) ? '0 : nxt_usr;
   assign hit     = go && !user && !clr && !load && (nxt_ctr == eff_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         reached_q <= 1'b0;
      end else if (clr) begin
         cnt_q     <= '0;
         reached_q <= 1'b0;
      end else if (load) begin
         cnt_q     <= ld_val;
         reached_q <= 1'b0;
      end else if (go) begin
         cnt_q <= user ? nxt_usr : nxt_ctr;
         if (hit) reached_q <= 1'b1;
      end
   end
endmodule

// File: rtl/lim_timer_irq.sv
module lim_timer_irq #(
   parameter bit RD_CLR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic set,
   input  logic rd_ack,
   output logic irq_q
);
   logic ack;

   generate
      if (RD_CLR) begin : g_rdclr
         assign ack = rd_ack;
      end else begin : g_noclr
         assign ack = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   irq_q <= 1'b0;
      else if (clr) irq_q <= 1'b0;
      else if (set) irq_q <= 1'b1;
      else if (ack) irq_q <= 1'b0;
   end
endmodule

// File: rtl/lim_timer.sv
module lim_timer
   import lim_timer_pkg::*;
#(
   parameter int unsigned W        = 32,
   parameter int unsigned NPROC    = 4,
   parameter int unsigned PROC_IDX = 0,
   parameter bit          RD_CLR   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         wr_en,
   input  logic         rd_en,
   input  logic [2:0]   addr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata,
   output logic         irq
);
   localparam int unsigned LIM_LO = W - 1;

   generate
      if (W < 8 || NPROC > W || PROC_IDX >= NPROC) begin : g_bad_cfg
         $error("lim_timer: parameter set out of range");
      end
   endgenerate

   logic [W-1:0] limit_q, eff_lim, cnt_q;
   logic         user_q, run_q, mode_sw, lim_rst_wr, reached_q, hit, clr, load;

   lim_timer_cfg #(.W(W), .NPROC(NPROC), .PROC_IDX(PROC_IDX)) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .limit_q(limit_q), .eff_lim(eff_lim), .user_q(user_q), .run_q(run_q),
      .mode_sw(mode_sw), .lim_rst_wr(lim_rst_wr)
   );

   assign clr  = mode_sw || lim_rst_wr;
   assign load = wr_en && (addr == SEL_COUNT) && user_q;

   lim_timer_cnt #(.W(W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .user(user_q), .run(run_q),
      .eff_lim(eff_lim), .clr(clr), .load(load), .ld_val(wdata),
      .cnt_q(cnt_q), .reached_q(reached_q), .hit(hit)
   );

   lim_timer_irq #(.RD_CLR(RD_CLR)) i_irq (
      .clk(clk), .rst_n(rst_n), .clr(clr), .set(hit),
      .rd_ack(rd_en && (addr == SEL_LIM_RST)), .irq_q(irq)
   );

   always_comb begin
      rdata = '0;
      case (addr)
         SEL_LIM_RST, SEL_LIM_KEEP: rdata = {reached_q, limit_q[LIM_LO-1:0]};
         SEL_COUNT:                 rdata = cnt_q;
         SEL_CTRL:                  rdata[0] = run_q;
         SEL_MODE:                  rdata[PROC_IDX] = user_q;
         default:                   rdata = '0;
      endcase
   end
endmodule

// File: rtl/lim_timer_chk.sv
module lim_timer_chk #(
   parameter int unsigned W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick,
   input logic         wr_en,
   input logic [2:0]   addr,
   input logic         irq,
   input logic [W-1:0] cnt,
   input logic         reached,
   input logic         user,
   input logic         run
);
   // R4
   lim_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == 3'd0 |=> !irq && cnt == '0);
   // R5
   keep_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == 3'd2 && !tick |=> $stable(cnt));
   // R8
   stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      user && !run && !wr_en |=> $stable(cnt));
   // R2
   irq_has_reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> reached);
   // R9
   user_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      user && $past(user) |-> !$rose(irq));
   // R10
   ignored_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == 3'd1 && !user && !tick |=> $stable(cnt));
endmodule

bind lim_timer lim_timer_chk #(.W(W)) i_lim_timer_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
   .irq(irq), .cnt(cnt_q), .reached(reached_q), .user(user_q), .run(run_q)
);

// File: tb/test_lim_timer.sv
module test_lim_timer;
   localparam int unsigned W  = 32;
   localparam int unsigned PI = 0;

   logic         clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]   addr = 3'd0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         irq;

   int errs = 0, chks = 0;

   logic [W-1:0] m_cnt = '0, m_lim = '1;
   logic         m_reach = 1'b0, m_irq = 1'b0, m_run = 1'b1, m_user = 1'b0;

   always #2 clk = ~clk;

   lim_timer #(.W(W), .PROC_IDX(PI)) i_lim_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   function automatic logic [W-1:0] exp_rd(input logic [2:0] a);
      logic [W-1:0] v;
      v = '0;
      case (a)
         3'd0, 3'd2: v = {m_reach, m_lim[W-2:0]};
         3'd1:       v = m_cnt;
         3'd3:       v[0] = m_run;
         3'd4:       v[PI] = m_user;
         default:    v = '0;
      endcase
      return v;
   endfunction

   task automatic chk(input string req, input string what, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      chks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic model(input logic t, input logic w, input logic r,
                        input logic [2:0] a, input logic [W-1:0] d);
      logic [W-1:0] eff, nx;
      logic set;
      set = 1'b0;
      eff = (m_lim == '0) ? '1 : m_lim;
      if (w && a == 3'd4 && d[PI] != m_user) begin
         m_user = d[PI]; m_cnt = '0; m_reach = 1'b0; m_irq = 1'b0; m_run = !d[PI];
      end else if (w && a == 3'd0) begin
         m_cnt = '0; m_reach = 1'b0; m_irq = 1'b0;
      end else if (w && a == 3'd1 && m_user) begin
         m_cnt = d; m_reach = 1'b0;
      end else if (t && (m_run || !m_user)) begin
         if (m_user) m_cnt = m_cnt + 1'b1;
         else begin
            nx = (m_cnt == eff) ? '0 : m_cnt + 1'b1;
            m_cnt = nx;
            if (nx == eff) begin m_reach = 1'b1; m_irq = 1'b1; set = 1'b1; end
         end
      end
      if (w && (a == 3'd0 || a == 3'd2)) m_lim = d;
      if (w && a == 3'd3 && m_user) m_run = d[0];
      if (r && a == 3'd0 && !set) m_irq = 1'b0;
   endtask

   task automatic step(input logic t, input logic w, input logic r, input logic [2:0] a,
                       input logic [W-1:0] d, input string req);
      @(negedge clk);
      tick = t; wr_en = w; rd_en = r; addr = a; wdata = d;
      #1;
      chk(req, "rdata", rdata, exp_rd(a));
      model(t, w, r, a, d);
      @(posedge clk);
      #1;
      chk(req, "irq", irq, m_irq);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  Result: errors=%0d of %0d checks", errs, chks);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state
      step(0, 0, 0, 3'd0, '0, "R1");
      step(0, 0, 0, 3'd1, '0, "R1");
      step(0, 0, 0, 3'd3, '0, "R1");
      step(0, 0, 0, 3'd4, '0, "R1");
      // R4 limit with restart; R2 reach and reload
      step(1, 0, 0, 3'd1, '0, "R1");
      step(0, 1, 0, 3'd0, 32'd3, "R4");
      step(0, 0, 0, 3'd1, '0, "R4");
      for (int i = 0; i < 3; i++) step(1, 0, 0, 3'd1, '0, "R2");
      step(0, 0, 0, 3'd0, '0, "R2");
      step(1, 0, 0, 3'd1, '0, "R2");
      step(1, 0, 0, 3'd1, '0, "R2");
      // R10 count write ignored in counter mode; R8 ctrl ignored
      step(0, 1, 0, 3'd1, 32'd99, "R10");
      step(0, 1, 0, 3'd3, 32'd0, "R8");
      step(0, 0, 0, 3'd1, '0, "R10");
      step(0, 0, 0, 3'd3, '0, "R8");
      step(1, 0, 0, 3'd1, '0, "R10");
      // R6 read acknowledge keeps reached
      step(0, 0, 1, 3'd0, '0, "R6");
      step(0, 0, 0, 3'd0, '0, "R6");
      // R11 write wins over tick
      step(1, 1, 0, 3'd0, 32'd5, "R11");
      step(1, 0, 0, 3'd1, '0, "R11");
      step(1, 0, 0, 3'd1, '0, "R11");
      // R5 non-resetting limit; R3 zero limit free-runs
      step(0, 1, 0, 3'd2, 32'd0, "R5");
      step(0, 0, 0, 3'd1, '0, "R5");
      for (int i = 0; i < 6; i++) step(1, 0, 0, 3'd1, '0, "R3");
      step(0, 0, 0, 3'd2, '0, "R3");
      // R7 user mode entry; R8 run control; R9 load and wrap
      step(0, 1, 0, 3'd4, 32'd1 << PI, "R7");
      step(0, 0, 0, 3'd4, '0, "R7");
      step(0, 0, 0, 3'd3, '0, "R7");
      step(1, 0, 0, 3'd1, '0, "R8");
      step(0, 1, 0, 3'd1, 32'hFFFF_FFFE, "R9");
      step(0, 1, 0, 3'd3, 32'd1, "R8");
      step(1, 0, 0, 3'd1, '0, "R9");
      step(1, 0, 0, 3'd1, '0, "R9");
      step(0, 0, 0, 3'd1, '0, "R9");
      step(0, 0, 0, 3'd6, '0, "R9");
      step(0, 1, 0, 3'd4, '0, "R7");
      step(0, 0, 0, 3'd3, '0, "R7");
      // random mix across all requirements (R2 R4 R5 R6 R7 R8 R9 R10)
      for (int i = 0; i < 1500; i++) begin
         logic [2:0]   a;
         logic [W-1:0] d;
         a = 3'($urandom % 6);
         case (a)
            3'd0, 3'd2: d = $urandom % 12;
            3'd1:       d = ($urandom % 2) ? (32'hFFFF_FFF0 | ($urandom % 16)) : ($urandom % 16);
            default:    d = $urandom;
         endcase
         step(($urandom % 2) == 0, ($urandom % 4) == 0, ($urandom % 3) == 0, a, d, "R2");
      end
      $display("  Result: errors=%0d of %0d checks", errs, chks);
      $finish;
   end
endmodule